// File: doc/BRIEF.md
# Bidirectional I/O Port with Change-Detect Interrupt

This block is an eight-pin general-purpose I/O port on a small register bus. Software sets a direction bit for each pin, writes an output latch, and turns on weak pull-ups for the whole port with one active-low control bit. Each alternate function can take over the direction and output value of its own pin through per-pin override inputs.

The upper four pins have a change detector. It compares each pin that is currently an input with a copy of the pins taken on the last access to the port data register. Any difference sets a sticky status flag. The flag drives an interrupt and a wake request when the interrupt enable is set. A typical use is a key matrix: software reads the port to take a new copy and then clears the flag.

Pin inputs pass through a two-flop synchronizer before they are read or compared. Register reads are combinational from the address. Writes take effect at the clock edge of the bus cycle.

Top module: `gpio_chg_port`

## Requirements
- R1: The direction register is at address 1. A bit of 1 makes its pin an input, with `pad_oe` low. A bit of 0 drives `pad_oe` high and places the latch bit on `pad_out`. Reading address 1 returns the register.
- R2: Reading address 0 returns the synchronized pin levels. A level applied to `pin_in` becomes readable after two rising edges.
- R3: A write to address 0 is a read-modify-write into the output latch. For each bit, the latch takes `bus_wdata` where `bus_wmask` is 1 and the synchronized pin level where it is 0.
- R4: Control register bit 7 (address 2) is the pull-up disable. When it is 0, `pad_pullup` is high on every pin whose `pad_oe` is low. When it is 1, all pull-ups are off.
- R5: When `alt_en` is set for a pin, `pad_oe` and `pad_out` for that pin come from `alt_oe` and `alt_out`. This overrides the direction and latch bits.
- R6: Pins 7:4 that are inputs are compared with a snapshot taken on every read or write of address 0. Any difference sets the flag at status bit 0 (address 3). Pins 3:0 and output pins never set it.
- R7: The flag stays set until software writes 0 to status bit 0. If a mismatch is still present, the flag sets again in the same cycle. Clearing it therefore needs a port access first.
- R8: Control bit 0 is the interrupt enable. `irq` equals flag AND enable. `wake` is the enable AND (flag OR a present mismatch).
- R9: A mismatch present during the cycle of an address-0 access is taken into the new snapshot and does not set the flag.
- R10: After reset, all direction bits are 1, the latch, snapshot, flag and enable are 0, and the pull-up disable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address (0 port, 1 direction, 2 control, 3 status) |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write select for port writes |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 8 | Asynchronous pin levels |
| alt_en | input | 8 | Alternate function takes the pin |
| alt_oe | input | 8 | Alternate output enable |
| alt_out | input | 8 | Alternate output value |
| pad_oe | output | 8 | Driver enable per pin |
| pad_out | output | 8 | Driver value per pin |
| pad_pullup | output | 8 | Weak pull-up enable per pin |
| irq | output | 1 | Change interrupt |
| wake | output | 1 | Change wake request |

## Verification
Pad outputs follow a register write at the edge that ends the write cycle. A pin change is visible in port reads two edges after it is applied. The flag sets on the third edge. The bench drives inputs on falling edges and waits a counted number of falling edges before it samples. For the race case it places the port read in the exact cycle when the synchronized pin first differs from the snapshot. Sweeps cover every pin pattern, every direction value and every single-pin change with the pin as input and as output.

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int WIDTH  = 8,
  parameter int CHG_LO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] bus_wmask,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_oe,
  input  logic [WIDTH-1:0] alt_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pullup,
  output logic             irq,
  output logic             wake
);
  localparam int CHG_W = WIDTH - CHG_LO;

  logic [WIDTH-1:0] sync1, pin_s, dir_q, lat_q;
  logic [CHG_W-1:0] snap_q, diff;
  logic             pu_dis, ie, flag_q, mism;
  logic             wr_port, wr_dir, wr_ctl, wr_sts, port_acc;

  assign wr_port  = bus_sel & bus_wr & (bus_addr == 2'd0);
  assign wr_dir   = bus_sel & bus_wr & (bus_addr == 2'd1);
  assign wr_ctl   = bus_sel & bus_wr & (bus_addr == 2'd2);
  assign wr_sts   = bus_sel & bus_wr & (bus_addr == 2'd3);
  assign port_acc = bus_sel & (bus_wr | bus_rd) & (bus_addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      pin_s <= '0;
    end else begin
      sync1 <= pin_in;
      pin_s <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q  <= '1;
      lat_q  <= '0;
      pu_dis <= 1'b1;
      ie     <= 1'b0;
    end else begin
      if (wr_dir)  dir_q <= bus_wdata;
      if (wr_port) lat_q <= (pin_s & ~bus_wmask) | (bus_wdata & bus_wmask);
      if (wr_ctl) begin
        pu_dis <= bus_wdata[WIDTH-1];
        ie     <= bus_wdata[0];
      end
    end

  assign pad_oe     = (alt_en & alt_oe) | (~alt_en & ~dir_q);
  assign pad_out    = (alt_en & alt_out) | (~alt_en & lat_q);
  assign pad_pullup = pu_dis ? '0 : ~pad_oe;

  assign diff = (pin_s[WIDTH-1:CHG_LO] ^ snap_q) & ~pad_oe[WIDTH-1:CHG_LO];
  assign mism = |diff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (port_acc) snap_q <= pin_s[WIDTH-1:CHG_LO];
      if (mism && !port_acc)           flag_q <= 1'b1;
      else if (wr_sts && !bus_wdata[0]) flag_q <= 1'b0;
    end

  assign irq  = flag_q & ie;
  assign wake = ie & (flag_q | mism);

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = pin_s;
      2'd1:    bus_rdata = dir_q;
      2'd2:    bus_rdata = {pu_dis, {(WIDTH-2){1'b0}}, ie};
      default: bus_rdata = {{(WIDTH-1){1'b0}}, flag_q};
    endcase
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int WIDTH  = 8,
  parameter int CHG_LO = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_wr,
  input logic [1:0]              bus_addr,
  input logic [WIDTH-1:0]        bus_wdata,
  input logic [WIDTH-1:0]        pad_oe,
  input logic [WIDTH-1:0]        pad_pullup,
  input logic                    irq,
  input logic [WIDTH-1:0]        dir_q,
  input logic [WIDTH-1:0]        lat_q,
  input logic [WIDTH-CHG_LO-1:0] snap_q,
  input logic                    flag_q,
  input logic                    port_acc
);
  logic clr;
  assign clr = bus_sel & bus_wr & (bus_addr == 2'd3) & ~bus_wdata[0];

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 2'd1) |=> $stable(dir_q)); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 2'd0) |=> $stable(lat_q)); // R3
  AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pullup) == '0); // R4
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !port_acc |=> $stable(snap_q)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q); // R8
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_oe(pad_oe),
  .pad_pullup(pad_pullup), .irq(irq), .dir_q(dir_q), .lat_q(lat_q),
  .snap_q(snap_q), .flag_q(flag_q), .port_acc(port_acc)
);

// File: tb/tb_gpio_chg_port.sv
module tb_gpio_chg_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_wmask = 0, bus_rdata;
  logic [7:0] pin_in = 0, alt_en = 0, alt_oe = 0, alt_out = 0;
  logic [7:0] pad_oe, pad_out, pad_pullup;
  logic       irq, wake;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_chg_port dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] m = 8'hFF);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_wmask = m;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v, exp_lat;
    settle(2);
    // R10 reset state
    chk(pad_oe == 8'h00, "R10 oe", pad_oe, 0);
    chk(pad_pullup == 8'h00, "R10 pullup", pad_pullup, 0);
    chk(irq == 0 && wake == 0, "R10 irq", irq, 0);
    rst_n = 1;
    settle(1);
    rd(2'd1, v); chk(v == 8'hFF, "R10 dir", v, 8'hFF);
    rd(2'd2, v); chk(v == 8'h80, "R10 ctl", v, 8'h80);
    rd(2'd3, v); chk(v == 8'h00, "R10 flag", v, 0);
    chk(pad_out == 8'h00, "R10 latch", pad_out, 0);

    // R2 every pin pattern, two edges to become readable
    for (int p = 0; p < 256; p++) begin
      pin_in = p[7:0];
      settle(2);
      rd(2'd0, v);
      chk(v == p[7:0], "R2 pins", v, p);
    end
    pin_in = 8'h00; settle(3);
    rd(2'd0, v);

    // R1 direction sweep with a known latch
    wr(2'd0, 8'h5A);
    for (int d = 0; d < 256; d++) begin
      wr(2'd1, d[7:0]);
      chk(pad_oe == ~d[7:0], "R1 oe", pad_oe, ~d[7:0]);
      chk(pad_out == 8'h5A, "R1 out", pad_out, 8'h5A);
      rd(2'd1, v); chk(v == d[7:0], "R1 readback", v, d);
    end

    // R4 pull-ups follow the disable bit and the direction
    wr(2'd2, 8'h00);
    for (int d = 0; d < 256; d += 17) begin
      wr(2'd1, d[7:0]);
      chk(pad_pullup == d[7:0], "R4 pull on", pad_pullup, d);
    end
    wr(2'd2, 8'h80);
    chk(pad_pullup == 8'h00, "R4 pull off", pad_pullup, 0);

    // R3 read-modify-write with mask
    wr(2'd1, 8'h00);
    for (int m = 0; m < 256; m += 51) begin
      pin_in = 8'hC3 ^ m[7:0]; settle(3);
      exp_lat = ((8'hC3 ^ m[7:0]) & ~m[7:0]) | (8'h96 & m[7:0]);
      wr(2'd0, 8'h96, m[7:0]);
      chk(pad_out == exp_lat, "R3 rmw", pad_out, exp_lat);
    end

    // R5 alternate override
    wr(2'd0, 8'h0F); wr(2'd1, 8'hFF);
    alt_en = 8'hF0; alt_oe = 8'hA5; alt_out = 8'h3C; #1;
    chk(pad_oe == 8'hA0, "R5 oe", pad_oe, 8'hA0);
    chk(pad_out == 8'h3F, "R5 out", pad_out, 8'h3F);
    alt_en = 0; alt_oe = 0; alt_out = 0;

    // R6/R7/R8 single-pin change, pin as input and as output
    wr(2'd2, 8'h81);
    for (int dirv = 0; dirv < 2; dirv++) begin
      for (int i = 0; i < 8; i++) begin
        bit expf;
        wr(2'd1, dirv ? ~(8'h01 << i) : 8'hFF);
        pin_in = 8'h00; settle(3);
        rd(2'd0, v); wr(2'd3, 8'h00);
        pin_in = 8'h01 << i; settle(4);
        expf = (i >= 4) && (dirv == 0);
        rd(2'd3, v);
        chk(v[0] == expf, "R6 flag", v[0], expf);
        chk(irq == expf, "R8 irq", irq, expf);
        if (expf) begin
          wr(2'd3, 8'h00);
          rd(2'd3, v); chk(v[0] == 1, "R7 sticky while mismatch", v[0], 1);
          chk(wake == 1, "R8 wake", wake, 1);
          rd(2'd0, v);
          wr(2'd3, 8'h00);
          rd(2'd3, v); chk(v[0] == 0, "R7 cleared", v[0], 0);
          chk(irq == 0, "R8 irq low", irq, 0);
        end
      end
    end

    // R8 enable gates irq and wake
    wr(2'd1, 8'hFF); pin_in = 8'h00; settle(3); rd(2'd0, v); wr(2'd3, 0);
    wr(2'd2, 8'h80);
    pin_in = 8'h80; settle(4);
    rd(2'd3, v); chk(v[0] == 1, "R8 flag no ie", v[0], 1);
    chk(irq == 0 && wake == 0, "R8 gated", {irq, wake}, 0);
    rd(2'd0, v); wr(2'd3, 0);

    // R9 change coinciding with the port access is absorbed
    pin_in = 8'h00;
    @(negedge clk); @(negedge clk);
    rd(2'd0, v);
    settle(3);
    rd(2'd3, v); chk(v[0] == 0, "R9 race absorbed", v[0], 0);

    finish_run();
  end
endmodule